// File: doc/BRIEF.md
# Spin-Lock Acquirer with Exponential Retry Delay

This unit sits between a local processor and a shared memory bus and takes ownership of a single-bit spin lock on the processor's behalf. When the processor asks for the lock, the unit performs an atomic test-and-set. It makes a read and then a write of 1 to the lock word, and keeps the bus lock line raised across both so that no other master can get between them. A read of 0 means the lock was free and is now owned, so the processor receives a one-cycle grant pulse. A read of 1 means another owner holds it. In that case the unit stays off the bus for a delay that starts at one cycle and doubles after every failed attempt, up to a configurable ceiling, and then tries again.

Releasing the lock is a plain, unlocked write of 0. A release asked for while the lock is not owned is refused with an error pulse and causes no bus traffic. A count of failed attempts in the current acquisition is available at the ports, so the retry pattern can be observed.

The controller has six states. IDLE moves to TAS_READ on an acquire request. TAS_READ moves to TAS_WRITE on the bus acknowledge. TAS_WRITE moves on its acknowledge to OWNED if the value read was 0, or to BACKOFF if it was 1. BACKOFF returns to TAS_READ when its delay expires. OWNED moves to RELEASE on a release request. RELEASE returns to IDLE on its acknowledge.

Top module: `spinlock_requester`

## Requirements
- R1: After reset, held, grant, rel_err, busy and bus_req are 0 and fail_cnt is 0.
- R2: An acquire issues a bus read of LOCK_ADDR followed by a write of 1 to LOCK_ADDR (bus_we=1, bus_wdata=1). bus_lock is 1 from the start of the read until the write is acknowledged.
- R3: If the test-and-set reads 0, grant is 1 for exactly one cycle and held then stays 1. The lock word then holds 1.
- R4: If the test-and-set reads 1, the unit leaves the bus idle (bus_req=0, busy=1) for a delay and then retries. The i-th delay (i counted from 0) of an acquisition lasts 2^i cycles.
- R5: The delay never exceeds MAX_DELAY (default 8) cycles. Once it reaches that value it stays there.
- R6: After a successful acquire, the delay of the next failed attempt is 1 cycle again.
- R7: A release request while held is 1 issues one unlocked write of 0 to the lock word. held then drops and the unit returns to idle.
- R8: A release request while held is 0 gives a one-cycle rel_err pulse in the following cycle and starts no bus access.
- R9: fail_cnt equals the number of failed attempts in the current acquisition. It is cleared when a new acquire starts and saturates at 2^FAIL_W-1.
- R10: An acquire request while the lock is already held causes no bus access and leaves held at 1.
- R11: With two units contending for the same lock word, at most one of them has held=1 in any cycle, and both eventually obtain the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Acquire request from the processor (taken in IDLE) |
| rel_req | input | 1 | Release request from the processor |
| grant | output | 1 | One-cycle pulse: lock obtained |
| held | output | 1 | Lock currently owned by this unit |
| busy | output | 1 | Acquisition in progress (test-and-set or backoff) |
| rel_err | output | 1 | One-cycle pulse: release refused, lock not owned |
| fail_cnt | output | FAIL_W | Failed attempts in the current acquisition |
| bus_req | output | 1 | Bus access request, held until bus_ack |
| bus_lock | output | 1 | Bus lock line, keeps other masters off between read and write |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Address of the lock word (LOCK_ADDR) |
| bus_wdata | output | 1 | Write data |
| bus_rdata | input | 1 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle access completion |

## Verification
A sweep holds the lock word at 1 for exactly n failed attempts, with n from 0 to 7, and then frees it. Each observed idle gap is compared with min(2^i, 8), which separates plain doubling, the saturation at the ceiling and the return of the delay to 1 between acquisitions. Separate patterns try a release while not owned, a repeated acquire while owned, and a release of a held lock. Those three show that refused or ignored requests leave the bus silent. Two units started in the same cycle on a free lock show that the locked read-write pair keeps the second unit out, and that the loser backs off until the winner releases.

// File: rtl/tas_pkg.sv
package tas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAS_READ,
        ST_TAS_WRITE,
        ST_BACKOFF,
        ST_OWNED,
        ST_RELEASE
    } tas_state_e;

endpackage

// File: rtl/tas_backoff.sv
module tas_backoff #(
    parameter int MAX_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_ev,
    input  logic win_ev,
    input  logic waiting,
    output logic wait_done
);
    localparam int DLY_W = $clog2(MAX_DELAY + 1);
    localparam logic [DLY_W:0] MAX_EXT = (DLY_W + 1)'(MAX_DELAY);

    logic [DLY_W-1:0] cur_delay;
    logic [DLY_W-1:0] remain;
    logic [DLY_W:0]   doubled;

    always_comb begin
        doubled = {cur_delay, 1'b0};
        if (doubled > MAX_EXT) begin
            doubled = MAX_EXT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_delay <= DLY_W'(1);
            remain    <= '0;
        end else begin
            if (win_ev) begin
                cur_delay <= DLY_W'(1);
            end else if (fail_ev) begin
                remain    <= cur_delay;
                cur_delay <= doubled[DLY_W-1:0];
            end else if (waiting && remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign wait_done = waiting && (remain == DLY_W'(1));

    AST_DELAY_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur_delay) == 1); // R4
    AST_DELAY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_delay) <= MAX_DELAY); // R5
    AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> remain != '0); // R4

endmodule

// File: rtl/tas_fail_ctr.sv
module tas_fail_ctr #(
    parameter int FAIL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [FAIL_W-1:0] count
);
    localparam logic [FAIL_W-1:0] FAIL_MAX = {FAIL_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != FAIL_MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_FAIL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FAIL_MAX && inc && !clr) |=> count == FAIL_MAX); // R9
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R9

endmodule

// File: rtl/tas_fsm.sv
module tas_fsm
    import tas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acq_req,
    input  logic       rel_req,
    input  logic       bus_ack,
    input  logic       bus_rdata,
    input  logic       wait_done,
    output tas_state_e state,
    output logic       start_ev,
    output logic       fail_ev,
    output logic       win_ev,
    output logic       grant,
    output logic       rel_err,
    output logic       held,
    output logic       busy,
    output logic       bus_req,
    output logic       bus_lock,
    output logic       bus_we,
    output logic       bus_wdata
);
    tas_state_e next_state;
    logic       old_val;

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:      if (acq_req)   next_state = ST_TAS_READ;
            ST_TAS_READ:  if (bus_ack)   next_state = ST_TAS_WRITE;
            ST_TAS_WRITE: if (bus_ack)   next_state = old_val ? ST_BACKOFF : ST_OWNED;
            ST_BACKOFF:   if (wait_done) next_state = ST_TAS_READ;
            ST_OWNED:     if (rel_req)   next_state = ST_RELEASE;
            ST_RELEASE:   if (bus_ack)   next_state = ST_IDLE;
            default:                     next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            old_val <= 1'b0;
            grant   <= 1'b0;
            rel_err <= 1'b0;
        end else begin
            state   <= next_state;
            if (state == ST_TAS_READ && bus_ack) begin
                old_val <= bus_rdata;
            end
            grant   <= win_ev;
            rel_err <= rel_req && (state != ST_OWNED);
        end
    end

    always_comb begin
        start_ev  = (state == ST_IDLE) && acq_req;
        fail_ev   = (state == ST_TAS_WRITE) && bus_ack && old_val;
        win_ev    = (state == ST_TAS_WRITE) && bus_ack && !old_val;
        held      = 1'b0;
        busy      = 1'b0;
        bus_req   = 1'b0;
        bus_lock  = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_TAS_READ: begin
                busy     = 1'b1;
                bus_req  = 1'b1;
                bus_lock = 1'b1;
            end
            ST_TAS_WRITE: begin
                busy      = 1'b1;
                bus_req   = 1'b1;
                bus_lock  = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = 1'b1;
            end
            ST_BACKOFF: busy = 1'b1;
            ST_OWNED:   held = 1'b1;
            ST_RELEASE: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant); // R3
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> held); // R3
    AST_ERR_ONLY_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> !held && !$past(held)); // R8
    AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (held && acq_req && !rel_req) |=> held && !bus_req); // R10

endmodule

// File: rtl/spinlock_requester.sv
module spinlock_requester
    import tas_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40,
    parameter int               MAX_DELAY = 8,
    parameter int               FAIL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_req,
    input  logic              rel_req,
    output logic              grant,
    output logic              held,
    output logic              busy,
    output logic              rel_err,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic              bus_req,
    output logic              bus_lock,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wdata,
    input  logic              bus_rdata,
    input  logic              bus_ack
);
    tas_state_e state;
    logic start_ev, fail_ev, win_ev, wait_done;

    tas_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_req   (acq_req),
        .rel_req   (rel_req),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .wait_done (wait_done),
        .state     (state),
        .start_ev  (start_ev),
        .fail_ev   (fail_ev),
        .win_ev    (win_ev),
        .grant     (grant),
        .rel_err   (rel_err),
        .held      (held),
        .busy      (busy),
        .bus_req   (bus_req),
        .bus_lock  (bus_lock),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata)
    );

    tas_backoff #(.MAX_DELAY(MAX_DELAY)) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_ev   (fail_ev),
        .win_ev    (win_ev),
        .waiting   (state == ST_BACKOFF),
        .wait_done (wait_done)
    );

    tas_fail_ctr #(.FAIL_W(FAIL_W)) u_fail (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ev),
        .inc   (fail_ev),
        .count (fail_cnt)
    );

    assign bus_addr = LOCK_ADDR;

    AST_RMW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && bus_ack && !bus_we) |=> (bus_lock && bus_we && bus_wdata)); // R2
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !bus_ack) |=> bus_lock); // R2
    AST_REL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_lock) |-> (bus_we && !bus_wdata)); // R7
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we))); // R2

endmodule

// File: tb/spinlock_requester_test.sv
module spinlock_requester_test;
    localparam int MAXD = 8;
    localparam int FW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0] acq, rel, gnt, hld, bsy, rerr, rq, lk, wen, wd, rd, ack;
    logic [FW-1:0] fc0, fc1;
    logic [7:0] ad0, ad1;
    logic mem;
    logic poke_en = 1'b0, poke_val = 1'b0;
    logic own_v;
    int   own;
    int   nchk = 0, nbad = 0, cyc = 0;

    spinlock_requester #(.MAX_DELAY(MAXD), .FAIL_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq[0]), .rel_req(rel[0]),
        .grant(gnt[0]), .held(hld[0]), .busy(bsy[0]), .rel_err(rerr[0]),
        .fail_cnt(fc0), .bus_req(rq[0]), .bus_lock(lk[0]), .bus_we(wen[0]),
        .bus_addr(ad0), .bus_wdata(wd[0]), .bus_rdata(rd[0]), .bus_ack(ack[0]));

    spinlock_requester #(.MAX_DELAY(MAXD), .FAIL_W(FW)) peer (
        .clk(clk), .rst_n(rst_n), .acq_req(acq[1]), .rel_req(rel[1]),
        .grant(gnt[1]), .held(hld[1]), .busy(bsy[1]), .rel_err(rerr[1]),
        .fail_cnt(fc1), .bus_req(rq[1]), .bus_lock(lk[1]), .bus_we(wen[1]),
        .bus_addr(ad1), .bus_wdata(wd[1]), .bus_rdata(rd[1]), .bus_ack(ack[1]));

    // shared memory with a locking arbiter, master 0 has priority
    always @(posedge clk) begin : mem_model
        int s;
        s = -1;
        ack <= 2'b00;
        if (!rst_n) begin
            mem   <= 1'b0;
            own_v <= 1'b0;
            own   <= 0;
            rd    <= 2'b00;
        end else begin
            if (poke_en) mem <= poke_val;
            if (own_v && lk[own]) s = own;
            else if (rq[0]) s = 0;
            else if (rq[1]) s = 1;
            own_v <= 1'b0;
            if (s >= 0) begin
                if (rq[s] && !ack[s]) begin
                    if (wen[s]) mem <= wd[s];
                    else rd[s] <= mem;
                    ack[s] <= 1'b1;
                end
                if (lk[s]) begin
                    own_v <= 1'b1;
                    own   <= s;
                end
            end
        end
    end

    int both_held = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && hld[0] && hld[1]) both_held <= both_held + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic poke(input logic v);
        @(negedge clk);
        poke_en = 1'b1; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic pulse_acq(input int m);
        @(negedge clk);
        acq[m] = 1'b1;
        @(negedge clk);
        acq[m] = 1'b0;
    endtask

    task automatic pulse_rel(input int m);
        @(negedge clk);
        rel[m] = 1'b1;
        @(negedge clk);
        rel[m] = 1'b0;
    endtask

    // acquire on unit 0 while the lock stays taken for n attempts
    task automatic acquire_after(input int n);
        int run, idx, lim;
        bit got, saw_lock_rd;
        run = 0; idx = 0; got = 0; saw_lock_rd = 0;
        poke(n > 0);
        @(negedge clk);
        acq[0] = 1'b1;
        for (int t = 0; t < 400 && !got; t++) begin
            @(negedge clk);
            acq[0] = 1'b0;
            if (rq[0] && lk[0] && !wen[0]) saw_lock_rd = 1;
            if (bsy[0] && !rq[0]) begin
                run++;
                if (idx == n - 1 && run == 1) begin
                    poke_en = 1'b1; poke_val = 1'b0;
                end else begin
                    poke_en = 1'b0;
                end
            end else begin
                poke_en = 1'b0;
                if (run > 0) begin
                    lim = (idx < 4) ? (1 << idx) : MAXD;
                    if (lim > MAXD) lim = MAXD;
                    if (idx == 0) check("R6 first delay after grant", run, 1);
                    else if (lim == MAXD) check("R5 saturated delay", run, lim);
                    else check("R4 doubling delay", run, lim);
                    idx++;
                    run = 0;
                end
            end
            if (gnt[0]) got = 1;
        end
        poke_en = 1'b0;
        check("R3 grant seen", int'(got), 1);
        check("R2 locked read issued", int'(saw_lock_rd), 1);
        check("R4 failed attempts observed", idx, n);
        check("R9 fail count", int'(fc0), n);
        @(negedge clk);
        check("R3 grant one cycle", int'(gnt[0]), 0);
        check("R3 held after grant", int'(hld[0]), 1);
        check("R3 lock word set", int'(mem), 1);
    endtask

    initial begin : stim
        bit ok;
        acq = 2'b00; rel = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 held", int'(hld[0]), 0);
        check("R1 bus_req", int'(rq[0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant", int'(gnt[0]), 0);
        check("R1 busy", int'(bsy[0]), 0);
        check("R1 rel_err", int'(rerr[0]), 0);
        check("R1 fail count", int'(fc0), 0);
        check("R2 lock address", int'(ad0), 8'h40);

        // R8: release when not held
        @(negedge clk); rel[0] = 1'b1;
        @(negedge clk); rel[0] = 1'b0;
        check("R8 rel_err pulse", int'(rerr[0]), 1);
        check("R8 no bus access", int'(rq[0]), 0);
        @(negedge clk);
        check("R8 rel_err one cycle", int'(rerr[0]), 0);

        // sweep of failed attempt counts
        for (int n = 0; n < 8; n++) begin
            acquire_after(n);
            // R10: acquire while held is ignored
            if (n == 2) begin
                @(negedge clk); acq[0] = 1'b1;
                ok = 1;
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk); acq[0] = 1'b0;
                    if (rq[0] || !hld[0]) ok = 0;
                end
                check("R10 acquire while held ignored", int'(ok), 1);
            end
            pulse_rel(0);
            repeat (3) @(negedge clk);
            check("R7 lock word cleared", int'(mem), 0);
            check("R7 held dropped", int'(hld[0]), 0);
            check("R7 unit idle", int'(bsy[0]) + int'(rq[0]), 0);
        end

        // R9: count cleared by a new acquire on a free lock
        acquire_after(0);
        pulse_rel(0);
        repeat (3) @(negedge clk);

        // R11: two units race for a free lock
        @(negedge clk);
        acq = 2'b11;
        @(negedge clk);
        acq = 2'b00;
        repeat (40) @(negedge clk);
        check("R11 unit 0 wins", int'(hld[0]), 1);
        check("R11 unit 1 backing off", int'(bsy[1]), 1);
        check("R11 loser failures seen", int'(fc1 > 0), 1);
        pulse_rel(0);
        ok = 0;
        for (int k = 0; k < 60 && !ok; k++) begin
            @(negedge clk);
            if (hld[1]) ok = 1;
        end
        check("R11 unit 1 obtains lock", int'(ok), 1);
        check("R11 lock word set", int'(mem), 1);
        pulse_rel(1);
        repeat (4) @(negedge clk);
        check("R7 lock word cleared by unit 1", int'(mem), 0);
        check("R11 never both held", both_held, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin : watchdog
        wait (cyc > 100000);
        nchk++; nbad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule